// File: doc/BRIEF.md
# Flash Self-Programming Command Arming Controller

This block sits between a microcontroller core and its flash controller and guards the self-programming path. Software writes an 8-bit control register. A command runs only if its select bit and the enable bit arrive in the same write. That write opens a short window. A store-to-program-memory strobe inside the window fires the selected command. When a lock-bit command is armed, a load-from-program-memory strobe in a slightly longer window fires a lock/fuse read instead. Armed bits clear themselves when the operation finishes, or when the window closes with no qualifying strobe.

Page erase and page write take their page number from the upper bits of the 16-bit Z pointer. They keep the CPU halted while they run. A parameterized busy counter stands in for the flash array and sets how long they take. Each issued command appears on the command port as a one-cycle `cmd_valid` pulse, with its operation code and page. This port has no back-pressure. The flash side must take every pulse. The busy counter paces the long operations, so a second command can never follow in the next cycle.

Top module: `spm_arm_ctrl`

## Requirements
- R1: After reset, and after any reset asserted mid-window, the control register reads 0x00, `cpu_halt` is low and `cmd_valid` is low. A store strobe after the reset issues nothing.
- R2: The readback layout is: bit 0 enable, bit 1 page erase, bit 2 page write, bit 3 lock-bit, bit 4 application read re-enable. Bits 7, 6 (application busy) and 5 always read 0, and values written to them have no effect.
- R3: A select bit is kept only if bit 0 is set in the same write. A write with no select bit, or with bit 0 clear, leaves the register at 0x00 and arms nothing.
- R4: With erase or write armed, a store strobe on the 1st to 4th rising edge after the write edge issues the command: `cmd_valid` is high for exactly one cycle after that edge. A strobe on the 5th edge issues nothing.
- R5: Operation codes are 0 for page erase, 1 for page write, 2 for lock-bit set, 3 for lock/fuse read and 4 for application re-enable. With the lock-bit select armed, a store strobe on edges 1–4 issues code 2, and a load strobe on edges 1–5 issues code 3.
- R6: With no qualifying strobe, the armed bits and the enable bit clear at the 4th edge after the write. For the lock-bit select they clear at the 5th edge.
- R7: For page erase and page write, `cmd_page` equals `zptr[15:7]` as sampled with the strobe. The lower seven bits have no effect.
- R8: Page erase and page write hold `cpu_halt` high for exactly BUSY_CYC cycles, starting the cycle after the accepted strobe. The register keeps its bits during that time, ignores writes and strobes, and reads 0x00 once the halt drops.
- R9: Application re-enable issues code 4 only when bit 4 was written together with bit 0 and a store strobe follows within 4 edges. A load strobe does not fire it.
- R10: If several select bits are written at once, only the highest-priority one is armed and read back. The order is erase, then write, then lock-bit, then application re-enable.
- R11: A store strobe with nothing armed, and a load strobe while a non-lock command is armed, issue nothing.
- R12: Lock-bit and application re-enable commands finish at once: the register reads 0x00 in the cycle after the strobe, and `cpu_halt` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| st_strobe | input | 1 | Store-to-program-memory instruction strobe |
| ld_strobe | input | 1 | Load-from-program-memory instruction strobe |
| zptr | input | 16 | Z pointer; upper bits select the page |
| cpu_halt | output | 1 | Holds the core during erase or write |
| cmd_valid | output | 1 | One-cycle command issue pulse |
| cmd_op | output | 3 | Operation code of the issued command |
| cmd_page | output | 9 | Page number of the issued command |

## Verification
The bench aims at the window edges. A strobe on the 4th edge must fire and one on the 5th must not, and the lock-bit case gets one extra edge for loads only. An off-by-one counter would either drop a legal strobe or accept a stale one. It also writes several select bits at once, writes without the enable bit, and sends loads to non-lock commands. A wrong priority or enable qualification would show up as the wrong readback or a spurious command. Finally it writes during a halt and counts the halt length. A design that let that write through, or cleared the bits early, would re-arm or release the core at the wrong cycle.

// File: rtl/spm_arm_pkg.sv
package spm_arm_pkg;

  localparam int CTL_W     = 8;
  localparam int BIT_EN    = 0;
  localparam int BIT_ERASE = 1;
  localparam int BIT_WRITE = 2;
  localparam int BIT_LOCK  = 3;
  localparam int BIT_APP   = 4;

  typedef enum logic [2:0] {
    OP_ERASE     = 3'd0,
    OP_WRITE     = 3'd1,
    OP_LOCK_SET  = 3'd2,
    OP_LOCK_READ = 3'd3,
    OP_APP_REEN  = 3'd4
  } spm_op_e;

  // Field order matches readback bits 4..1.
  typedef struct packed {
    logic app;
    logic lock;
    logic wr;
    logic erase;
  } spm_sel_t;

endpackage

// File: rtl/spm_sel_decode.sv
module spm_sel_decode
  import spm_arm_pkg::*;
(
  input  logic [CTL_W-1:0] wdata,
  output spm_sel_t         sel,
  output logic             arm_req
);

  logic unused_rsvd;
  assign unused_rsvd = ^wdata[CTL_W-1:BIT_APP+1];

  // Priority pick: erase > write > lock > app; nothing without enable.
  always_comb begin
    sel = '0;
    if (wdata[BIT_EN]) begin
      if (wdata[BIT_ERASE])      sel.erase = 1'b1;
      else if (wdata[BIT_WRITE]) sel.wr    = 1'b1;
      else if (wdata[BIT_LOCK])  sel.lock  = 1'b1;
      else if (wdata[BIT_APP])   sel.app   = 1'b1;
    end
  end

  assign arm_req = |sel;

endmodule

// File: rtl/spm_window.sv
module spm_window #(
  parameter int ST_WIN = 4,
  parameter int LD_WIN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  input  logic lock_mode,
  output logic st_ok,
  output logic ld_ok,
  output logic expire
);

  localparam int AW = $clog2(LD_WIN + 2);
  localparam logic [AW-1:0] ST_LIM = AW'(ST_WIN);
  localparam logic [AW-1:0] LD_LIM = AW'(LD_WIN);

  // age = index of the upcoming edge since the arming write
  logic [AW-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   age <= '0;
    else if (arm) age <= AW'(1);
    else if (run) age <= age + 1'b1;
  end

  assign st_ok  = (age != '0) && (age <= ST_LIM);
  assign ld_ok  = (age != '0) && (age <= LD_LIM);
  assign expire = run && (age == (lock_mode ? LD_LIM : ST_LIM));

  p_age_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (age != '0 && age <= LD_LIM));

endmodule

// File: rtl/spm_busy.sv
module spm_busy #(
  parameter int BUSY_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(BUSY_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/spm_arm_ctrl.sv
module spm_arm_ctrl
  import spm_arm_pkg::*;
#(
  parameter int ZW       = 16,
  parameter int PG_OFS   = 7,
  parameter int ST_WIN   = 4,
  parameter int LD_WIN   = 5,
  parameter int BUSY_CYC = 24,
  localparam int PW      = ZW - PG_OFS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          st_strobe,
  input  logic          ld_strobe,
  input  logic [ZW-1:0] zptr,
  output logic          cpu_halt,
  output logic          cmd_valid,
  output logic [2:0]    cmd_op,
  output logic [PW-1:0] cmd_page
);

  spm_sel_t arm_q;
  logic     en_q;

  spm_sel_t sel_w;
  logic     arm_req;
  logic     st_ok, ld_ok, expire;
  logic     busy, done;
  logic     acc_st, acc_ld, accept, long_op, run, wr_ok, start;
  spm_op_e  op_nxt;

  logic unused_zlow;
  assign unused_zlow = ^zptr[PG_OFS-1:0];

  spm_sel_decode u_dec (
    .wdata   (reg_wdata),
    .sel     (sel_w),
    .arm_req (arm_req)
  );

  assign long_op = arm_q.erase | arm_q.wr;
  assign acc_st  = st_strobe & en_q & st_ok & ~busy;
  assign acc_ld  = ld_strobe & arm_q.lock & ld_ok & ~busy;
  assign accept  = acc_st | acc_ld;
  assign start   = acc_st & long_op;
  assign run     = en_q & ~busy & ~accept;
  assign wr_ok   = reg_we & ~busy & ~accept;

  spm_window #(.ST_WIN(ST_WIN), .LD_WIN(LD_WIN)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (wr_ok & arm_req),
    .run       (run),
    .lock_mode (arm_q.lock),
    .st_ok     (st_ok),
    .ld_ok     (ld_ok),
    .expire    (expire)
  );

  spm_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  // Arming register: load on write, self-clear on finish or timeout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_ok) begin
      arm_q <= sel_w;
      en_q  <= arm_req;
    end else if ((accept && !long_op) || expire || done) begin
      arm_q <= '0;
      en_q  <= 1'b0;
    end
  end

  always_comb begin
    if (arm_q.erase)     op_nxt = OP_ERASE;
    else if (arm_q.wr)   op_nxt = OP_WRITE;
    else if (arm_q.lock) op_nxt = acc_ld ? OP_LOCK_READ : OP_LOCK_SET;
    else                 op_nxt = OP_APP_REEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_page  <= '0;
    end else begin
      cmd_valid <= accept;
      if (accept) begin
        cmd_op   <= op_nxt;
        cmd_page <= zptr[ZW-1:PG_OFS];
      end
    end
  end

  assign cpu_halt  = busy;
  assign reg_rdata = {3'b000, arm_q, en_q};

  p_one_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arm_q));

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_expire_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reg_we) |=> (reg_rdata == 8'h00));

  p_idle_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_strobe && !en_q) |=> !cmd_valid);

  p_halt_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_halt) |-> (reg_rdata == 8'h00));

  p_quick_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !long_op) |=> (reg_rdata == 8'h00 && !cpu_halt));

endmodule

// File: tb/spm_arm_ctrl_test.sv
`timescale 1ns/1ps
module spm_arm_ctrl_test;

  localparam int BUSY = 24;
  localparam int NV   = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       st_strobe = 1'b0;
  logic       ld_strobe = 1'b0;
  logic [15:0] zptr = '0;
  logic       cpu_halt, cmd_valid;
  logic [2:0] cmd_op;
  logic [8:0] cmd_page;

  always #2.5 clk = ~clk;

  spm_arm_ctrl #(.ZW(16), .PG_OFS(7), .ST_WIN(4), .LD_WIN(5), .BUSY_CYC(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .st_strobe(st_strobe), .ld_strobe(ld_strobe),
    .zptr(zptr), .cpu_halt(cpu_halt), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_page(cmd_page)
  );

  // {wdata, exp_readback, strobe_edge, kind(1 store,2 load), zptr, exp_valid, exp_op}
  localparam logic [41:0] VECS [NV] = '{
    {8'h03, 8'h03, 4'd1, 2'd1, 16'h1A85, 1'b1, 3'd0},  // R4 erase edge 1
    {8'h05, 8'h05, 4'd4, 2'd1, 16'hFFFF, 1'b1, 3'd1},  // R4 write edge 4
    {8'h03, 8'h03, 4'd5, 2'd1, 16'h1234, 1'b0, 3'd0},  // R4 edge 5 too late
    {8'h09, 8'h09, 4'd2, 2'd1, 16'h0000, 1'b1, 3'd2},  // R5 lock set
    {8'h09, 8'h09, 4'd5, 2'd2, 16'h0000, 1'b1, 3'd3},  // R5 lock read edge 5
    {8'h09, 8'h09, 4'd5, 2'd1, 16'h0000, 1'b0, 3'd0},  // R5 store edge 5 late
    {8'h11, 8'h11, 4'd3, 2'd1, 16'h0000, 1'b1, 3'd4},  // R9 app reenable
    {8'h11, 8'h11, 4'd2, 2'd2, 16'h0000, 1'b0, 3'd0},  // R9 load ignored
    {8'h02, 8'h00, 4'd1, 2'd1, 16'h0000, 1'b0, 3'd0},  // R3 no enable
    {8'h07, 8'h03, 4'd1, 2'd1, 16'h8080, 1'b1, 3'd0},  // R10 erase wins
    {8'h1D, 8'h05, 4'd2, 2'd1, 16'h7F7F, 1'b1, 3'd1},  // R10 write wins
    {8'hFF, 8'h03, 4'd3, 2'd1, 16'h4001, 1'b1, 3'd0},  // R2 reserved ignored
    {8'hE9, 8'h09, 4'd1, 2'd2, 16'h0000, 1'b1, 3'd3},  // R2 lock read
    {8'h01, 8'h00, 4'd1, 2'd1, 16'h0000, 1'b0, 3'd0},  // R3 enable alone
    {8'h11, 8'h11, 4'd5, 2'd1, 16'h0000, 1'b0, 3'd0},  // R9 too late
    {8'h10, 8'h00, 4'd1, 2'd1, 16'h0000, 1'b0, 3'd0},  // R9 no enable
    {8'h03, 8'h03, 4'd2, 2'd2, 16'h0000, 1'b0, 3'd0}   // R11 load on erase
  };

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic write_reg(input logic [7:0] d);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input bit st, input bit ld);
    st_strobe = st;
    ld_strobe = ld;
    @(negedge clk);
    st_strobe = 1'b0;
    ld_strobe = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  wd, erd;
    logic [3:0]  dly;
    logic [1:0]  kind;
    logic [15:0] z;
    logic        ev;
    logic [2:0]  eop;
    int          hc;
    int          exp_h;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reg_rdata == 8'h00, "R1 reset readback", reg_rdata, 8'h00);
    chk(cpu_halt == 1'b0, "R1 reset halt", cpu_halt, 0);
    chk(cmd_valid == 1'b0, "R1 reset valid", cmd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wd   = VECS[i][41:34];
      erd  = VECS[i][33:26];
      dly  = VECS[i][25:22];
      kind = VECS[i][21:20];
      z    = VECS[i][19:4];
      ev   = VECS[i][3];
      eop  = VECS[i][2:0];
      write_reg(wd);
      chk(reg_rdata == erd, "R10/R2/R3 readback", reg_rdata, erd);
      repeat (int'(dly) - 1) @(negedge clk);
      zptr = z;
      pulse(kind == 2'd1, kind == 2'd2);
      chk(cmd_valid == ev, "R4 issue", cmd_valid, ev);
      if (ev) begin
        chk(cmd_op == eop, "R5 opcode", cmd_op, eop);
        if (eop < 3'd2)
          chk(cmd_page == z[15:7], "R7 page", cmd_page, z[15:7]);
        else
          chk(reg_rdata == 8'h00, "R12 immediate clear", reg_rdata, 0);
      end
      exp_h = (ev && eop < 3'd2) ? BUSY : 0;
      if (exp_h != 0)
        chk(reg_rdata == erd, "R8 bits held", reg_rdata, erd);
      hc = 0;
      while (cpu_halt && hc < 1000) begin
        hc++;
        @(negedge clk);
      end
      chk(hc == exp_h, "R8 halt length", hc, exp_h);
      repeat (6) @(negedge clk);
      chk(reg_rdata == 8'h00, "R6 cleared", reg_rdata, 0);
    end

    // R6 exact store-window expiry
    write_reg(8'h03);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      chk(reg_rdata == 8'h03, "R6 still armed", reg_rdata, 8'h03);
    end
    @(negedge clk);
    chk(reg_rdata == 8'h00, "R6 store expiry", reg_rdata, 0);

    // R6 exact lock-window expiry
    write_reg(8'h09);
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      chk(reg_rdata == 8'h09, "R6 lock armed", reg_rdata, 8'h09);
    end
    @(negedge clk);
    chk(reg_rdata == 8'h00, "R6 lock expiry", reg_rdata, 0);

    // R11 idle store strobe
    pulse(1'b1, 1'b0);
    chk(cmd_valid == 1'b0, "R11 idle store", cmd_valid, 0);
    chk(cpu_halt == 1'b0, "R11 idle halt", cpu_halt, 0);

    // R8 write during halt ignored
    write_reg(8'h03);
    zptr = 16'h2000;
    pulse(1'b1, 1'b0);
    chk(cpu_halt == 1'b1, "R8 halt starts", cpu_halt, 1);
    write_reg(8'h09);
    chk(reg_rdata == 8'h03, "R8 write ignored", reg_rdata, 8'h03);
    pulse(1'b0, 1'b1);
    chk(cmd_valid == 1'b0, "R8 strobe during halt", cmd_valid, 0);
    hc = 0;
    while (cpu_halt && hc < 1000) begin
      hc++;
      @(negedge clk);
    end
    chk(reg_rdata == 8'h00, "R8 clear after halt", reg_rdata, 0);
    pulse(1'b0, 1'b1);
    chk(cmd_valid == 1'b0, "R8 no late lock read", cmd_valid, 0);

    // R1 reset inside a window
    write_reg(8'h05);
    rst_n = 1'b0;
    @(negedge clk);
    chk(reg_rdata == 8'h00, "R1 mid reset", reg_rdata, 0);
    rst_n = 1'b1;
    pulse(1'b1, 1'b0);
    chk(cmd_valid == 1'b0, "R1 no issue after reset", cmd_valid, 0);
    chk(cpu_halt == 1'b0, "R1 no halt after reset", cpu_halt, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule